// File: doc/BRIEF.md
# Interrupt Acknowledge and Nested Completion Tracker

This block serves one processor's interrupt interface. It handles acknowledge reads and end-of-interrupt (EOI) writes. An acknowledge accepts the interrupt that the arbiter currently offers as most urgent, but only when that interrupt's priority beats the one already running. When it accepts, it tells the pending logic to drop the request. An EOI retires an active interrupt. If the retired interrupt is a level-triggered source whose line is still high, the block asks for it to be marked pending again.

Active interrupts are kept as a preemption chain. Each interrupt ID owns a 10-bit link that names the interrupt it displaced. An EOI for the running interrupt restores the running ID from that link. An EOI for an interrupt deeper in the chain does not count as an error: a small walker follows the chain one link per cycle and splices the completed entry out. While the walker runs, the block reports busy and refuses new work. Arbitration among pending sources happens upstream and is not part of this block.

Top module: `ack_eoi_tracker`

## Requirements
- R1: After reset, `run_id` is 1023 and `run_prio` is 0x100. `busy`, `ack_valid`, `pclr_valid` and `pset_valid` are low, and every link entry holds 1023.
- R2: An acknowledge is answered with ID 1023 when any of these holds: `hp_id` is 1023, `hp_id` is not below NUM_IRQ, or the priority of `hp_id` is not strictly below `run_prio`. Such an acknowledge changes no state and raises no pending clear.
- R3: A successful acknowledge answers with `hp_id`. It stores the previous `run_id` as the link of `hp_id` and makes `hp_id` the running interrupt.
- R4: In the cycle after a successful acknowledge, `pclr_valid` pulses with `pclr_id` equal to the acknowledged ID. `pclr_all` copies that interrupt's `model_all` bit: 1 means clear for every processor, 0 means clear for this processor only.
- R5: `run_prio` is `{1'b0, priority}` of the running interrupt, or 0x100 when `run_id` is 1023. The priority of interrupt i is `prio_table[8*i +: 8]`.
- R6: An EOI is ignored when its ID is not below NUM_IRQ, or when `run_id` is 1023. An ignored EOI raises no pending set and leaves the running ID and the chain unchanged.
- R7: For an accepted EOI of interrupt i, `pset_valid` pulses in the next cycle with `pset_id` = i when all of these hold: `trig_edge[i]` = 0 (0 means level, 1 means edge), `irq_enable[i]`, `line_level[i]` and `targets_self[i]`.
- R8: An accepted EOI of the running ID makes the running ID equal to that interrupt's stored link.
- R9: An accepted EOI of any other ID starts a walk from `run_id`. The walk finds the entry whose link equals the completed ID and replaces that link with the completed ID's own link. It stops at a link of 1023. The running ID does not change.
- R10: A walk examines one link per cycle, with `busy` high until it ends. An acknowledge that arrives while `busy` is high is answered with 1023 and has no effect. An EOI that arrives while `busy` is high is ignored.
- R11: When an acknowledge and an EOI arrive in the same cycle, the EOI is processed and the acknowledge is answered with 1023 with no effect.
- R12: Every `ack_req` cycle is answered by a one-cycle `ack_valid` pulse in the next cycle, carrying `ack_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_id | input | 10 | Highest-pending ID offered by the arbiter (1023 = none) |
| prio_table | input | 8*NUM_IRQ | Priority of each interrupt, 8 bits per ID, lower is more urgent |
| trig_edge | input | NUM_IRQ | 1 = edge-triggered, 0 = level-triggered |
| model_all | input | NUM_IRQ | 1 = an acknowledge clears pending for all processors |
| irq_enable | input | NUM_IRQ | Per-interrupt enable |
| line_level | input | NUM_IRQ | Raw input line level |
| targets_self | input | NUM_IRQ | Interrupt is routed to this processor |
| ack_req | input | 1 | Acknowledge read strobe |
| eoi_req | input | 1 | End-of-interrupt write strobe |
| eoi_id | input | 10 | ID written with the EOI |
| ack_valid | output | 1 | Acknowledge response pulse |
| ack_id | output | 10 | Acknowledged ID, or 1023 |
| run_id | output | 10 | Running interrupt ID (1023 = none) |
| run_prio | output | 9 | Running priority (0x100 when idle) |
| pclr_valid | output | 1 | Pending-clear request |
| pclr_id | output | 10 | ID to clear |
| pclr_all | output | 1 | Clear for all processors rather than this one |
| pset_valid | output | 1 | Pending-set request (level re-arm) |
| pset_id | output | 10 | ID to set pending |
| busy | output | 1 | Chain walk in progress |

## Verification
The two operations that can share a cycle are an acknowledge and an EOI. The bench provokes this by raising both strobes on one edge, with a more urgent interrupt offered and the running ID being completed. It expects the running ID to fall back to the stored link and the acknowledge to be answered with 1023. A related overlap is an acknowledge or EOI issued while a mid-chain walk is still in flight. The bench checks that the answer is 1023, that the running ID is unchanged, and that the chain later unwinds in the order its own model predicts.

// File: rtl/ack_eoi_pkg.sv
package ack_eoi_pkg;
    localparam int ID_W    = 10;
    localparam int PRIO_W  = 8;
    localparam int RPRIO_W = PRIO_W + 1;
    localparam logic [ID_W-1:0]    ID_NONE    = 10'd1023;
    localparam logic [RPRIO_W-1:0] RPRIO_IDLE = 9'h100;

    typedef enum logic {
        WALK_IDLE,
        WALK_STEP
    } walk_state_e;
endpackage

// File: rtl/aet_prio_lookup.sv
module aet_prio_lookup
    import ack_eoi_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_table,
    input  logic [ID_W-1:0]           id,
    output logic [RPRIO_W-1:0]        prio
);
    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_IRQ);

    logic [PRIO_W-1:0] entry [NUM_IRQ];

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_unpack
        assign entry[g] = prio_table[g*PRIO_W +: PRIO_W];
    end

    // IDs outside the table and the "none" ID read as the idle priority.
    always_comb begin
        if (id < LIMIT) begin
            prio = {1'b0, entry[id[IDX_W-1:0]]};
        end else begin
            prio = RPRIO_IDLE;
        end
    end
endmodule

// File: rtl/aet_link_store.sv
module aet_link_store
    import ack_eoi_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_addr,
    input  logic [ID_W-1:0] wr_data,
    input  logic [ID_W-1:0] rd_addr_a,
    output logic [ID_W-1:0] rd_data_a,
    input  logic [ID_W-1:0] rd_addr_b,
    output logic [ID_W-1:0] rd_data_b
);
    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_IRQ);

    logic [ID_W-1:0] links_q [NUM_IRQ];
    logic [ID_W-1:0] links_d [NUM_IRQ];

    always_comb begin
        links_d = links_q;
        if (wr_en && (wr_addr < LIMIT)) begin
            links_d[wr_addr[IDX_W-1:0]] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                links_q[i] <= ID_NONE;
            end
        end else begin
            links_q <= links_d;
        end
    end

    always_comb begin
        rd_data_a = (rd_addr_a < LIMIT) ? links_q[rd_addr_a[IDX_W-1:0]] : ID_NONE;
        rd_data_b = (rd_addr_b < LIMIT) ? links_q[rd_addr_b[IDX_W-1:0]] : ID_NONE;
    end
endmodule

// File: rtl/aet_chain_walker.sv
module aet_chain_walker
    import ack_eoi_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [ID_W-1:0] start_ptr,
    input  logic [ID_W-1:0] start_tgt,
    input  logic [ID_W-1:0] link_at_ptr,
    input  logic [ID_W-1:0] link_at_tgt,
    output logic            busy,
    output logic [ID_W-1:0] ptr,
    output logic [ID_W-1:0] tgt,
    output logic            wr_en,
    output logic [ID_W-1:0] wr_addr,
    output logic [ID_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(NUM_IRQ + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(NUM_IRQ - 1);

    typedef struct packed {
        walk_state_e     st;
        logic [ID_W-1:0] ptr;
        logic [ID_W-1:0] tgt;
        logic [CNT_W-1:0] steps;
    } walk_t;

    walk_t q, d;

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_addr = q.ptr;
        wr_data = link_at_tgt;
        unique case (q.st)
            WALK_IDLE: begin
                if (start) begin
                    d.st    = WALK_STEP;
                    d.ptr   = start_ptr;
                    d.tgt   = start_tgt;
                    d.steps = '0;
                end
            end
            WALK_STEP: begin
                if (link_at_ptr == ID_NONE) begin
                    d.st = WALK_IDLE;
                end else if (link_at_ptr == q.tgt) begin
                    // splice the completed entry out of the chain
                    wr_en = 1'b1;
                    d.st  = WALK_IDLE;
                end else if (q.steps == LAST_STEP) begin
                    // bound on chain length: never loop forever
                    d.st = WALK_IDLE;
                end else begin
                    d.ptr   = link_at_ptr;
                    d.steps = q.steps + 1'b1;
                end
            end
            default: d.st = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: WALK_IDLE, ptr: ID_NONE, tgt: ID_NONE, steps: '0};
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st == WALK_STEP);
    assign ptr  = q.ptr;
    assign tgt  = q.tgt;
endmodule

// File: rtl/ack_eoi_tracker.sv
module ack_eoi_tracker
    import ack_eoi_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ID_W-1:0]           hp_id,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_table,
    input  logic [NUM_IRQ-1:0]        trig_edge,
    input  logic [NUM_IRQ-1:0]        model_all,
    input  logic [NUM_IRQ-1:0]        irq_enable,
    input  logic [NUM_IRQ-1:0]        line_level,
    input  logic [NUM_IRQ-1:0]        targets_self,
    input  logic                      ack_req,
    input  logic                      eoi_req,
    input  logic [ID_W-1:0]           eoi_id,
    output logic                      ack_valid,
    output logic [ID_W-1:0]           ack_id,
    output logic [ID_W-1:0]           run_id,
    output logic [RPRIO_W-1:0]        run_prio,
    output logic                      pclr_valid,
    output logic [ID_W-1:0]           pclr_id,
    output logic                      pclr_all,
    output logic                      pset_valid,
    output logic [ID_W-1:0]           pset_id,
    output logic                      busy
);
    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_IRQ);

    typedef struct packed {
        logic [ID_W-1:0] run_id;
        logic            ack_valid;
        logic [ID_W-1:0] ack_id;
        logic            pclr_valid;
        logic [ID_W-1:0] pclr_id;
        logic            pclr_all;
        logic            pset_valid;
        logic [ID_W-1:0] pset_id;
    } trk_t;

    trk_t q, d;

    logic [RPRIO_W-1:0] hp_prio;
    logic [RPRIO_W-1:0] cur_prio;
    logic               walk_busy;
    logic               walk_start;
    logic [ID_W-1:0]    walk_ptr;
    logic [ID_W-1:0]    walk_tgt;
    logic               walk_we;
    logic [ID_W-1:0]    walk_wa;
    logic [ID_W-1:0]    walk_wd;
    logic               lnk_we;
    logic [ID_W-1:0]    lnk_wa;
    logic [ID_W-1:0]    lnk_wd;
    logic [ID_W-1:0]    lnk_ra;
    logic [ID_W-1:0]    lnk_at_ptr;
    logic [ID_W-1:0]    lnk_at_tgt;
    logic               ack_take;
    logic               eoi_take;
    logic               relevel;
    logic [IDX_W-1:0]   h_idx;
    logic [IDX_W-1:0]   e_idx;

    aet_prio_lookup #(.NUM_IRQ(NUM_IRQ)) i_hp_prio (
        .prio_table (prio_table),
        .id         (hp_id),
        .prio       (hp_prio)
    );

    aet_prio_lookup #(.NUM_IRQ(NUM_IRQ)) i_run_prio (
        .prio_table (prio_table),
        .id         (q.run_id),
        .prio       (cur_prio)
    );

    // one write port shared: the walker owns it while busy, acks otherwise
    assign lnk_ra = walk_busy ? walk_ptr : q.run_id;
    assign lnk_we = walk_busy ? walk_we  : ack_take;
    assign lnk_wa = walk_busy ? walk_wa  : hp_id;
    assign lnk_wd = walk_busy ? walk_wd  : q.run_id;

    aet_link_store #(.NUM_IRQ(NUM_IRQ)) i_links (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (lnk_we),
        .wr_addr   (lnk_wa),
        .wr_data   (lnk_wd),
        .rd_addr_a (lnk_ra),
        .rd_data_a (lnk_at_ptr),
        .rd_addr_b (walk_tgt),
        .rd_data_b (lnk_at_tgt)
    );

    aet_chain_walker #(.NUM_IRQ(NUM_IRQ)) i_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (walk_start),
        .start_ptr   (q.run_id),
        .start_tgt   (eoi_id),
        .link_at_ptr (lnk_at_ptr),
        .link_at_tgt (lnk_at_tgt),
        .busy        (walk_busy),
        .ptr         (walk_ptr),
        .tgt         (walk_tgt),
        .wr_en       (walk_we),
        .wr_addr     (walk_wa),
        .wr_data     (walk_wd)
    );

    assign h_idx = hp_id[IDX_W-1:0];
    assign e_idx = eoi_id[IDX_W-1:0];

    always_comb begin
        // EOI has precedence over a same-cycle acknowledge; a walk blocks both
        eoi_take = eoi_req && !walk_busy && (eoi_id < LIMIT) && (q.run_id != ID_NONE);
        ack_take = ack_req && !eoi_req && !walk_busy && (hp_id != ID_NONE)
                   && (hp_prio < cur_prio);
        relevel  = 1'b0;
        if (eoi_id < LIMIT) begin
            relevel = !trig_edge[e_idx] && irq_enable[e_idx]
                      && line_level[e_idx] && targets_self[e_idx];
        end
        walk_start = eoi_take && (eoi_id != q.run_id);

        d            = q;
        d.ack_valid  = ack_req;
        d.ack_id     = ack_take ? hp_id : ID_NONE;
        d.pclr_valid = 1'b0;
        d.pset_valid = 1'b0;

        if (ack_take) begin
            d.run_id     = hp_id;
            d.pclr_valid = 1'b1;
            d.pclr_id    = hp_id;
            d.pclr_all   = model_all[h_idx];
        end

        if (eoi_take) begin
            if (relevel) begin
                d.pset_valid = 1'b1;
                d.pset_id    = eoi_id;
            end
            if (eoi_id == q.run_id) begin
                d.run_id = lnk_at_ptr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{run_id: ID_NONE, ack_valid: 1'b0, ack_id: ID_NONE,
                   pclr_valid: 1'b0, pclr_id: ID_NONE, pclr_all: 1'b0,
                   pset_valid: 1'b0, pset_id: ID_NONE};
        end else begin
            q <= d;
        end
    end

    assign ack_valid  = q.ack_valid;
    assign ack_id     = q.ack_id;
    assign run_id     = q.run_id;
    assign run_prio   = cur_prio;
    assign pclr_valid = q.pclr_valid;
    assign pclr_id    = q.pclr_id;
    assign pclr_all   = q.pclr_all;
    assign pset_valid = q.pset_valid;
    assign pset_id    = q.pset_id;
    assign busy       = walk_busy;
endmodule

// File: rtl/aet_tracker_chk.sv
module aet_tracker_chk
    import ack_eoi_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ack_req,
    input logic               eoi_req,
    input logic               busy,
    input logic               ack_valid,
    input logic [ID_W-1:0]    ack_id,
    input logic [ID_W-1:0]    run_id,
    input logic [RPRIO_W-1:0] run_prio,
    input logic               pclr_valid,
    input logic [ID_W-1:0]    pclr_id,
    input logic               pset_valid,
    input logic [ID_W-1:0]    pset_id
);
    localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_IRQ);

    assert_spurious_keeps_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id == ID_NONE && !$past(eoi_req)) |-> run_id == $past(run_id));

    assert_ack_becomes_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id != ID_NONE) |-> run_id == ack_id);

    assert_clear_follows_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pclr_valid |-> (ack_valid && ack_id != ID_NONE && pclr_id == ack_id));

    assert_idle_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_id == ID_NONE) |-> (run_prio == RPRIO_IDLE));

    assert_pset_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pset_valid |-> (pset_id < LIMIT));

    assert_busy_refuses_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && ack_valid) |-> ack_id == ID_NONE);

    assert_collision_eoi_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ack_req && eoi_req) |-> (ack_valid && ack_id == ID_NONE));

    assert_response_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid == $past(ack_req));
endmodule

bind ack_eoi_tracker aet_tracker_chk #(.NUM_IRQ(NUM_IRQ)) i_aet_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_req    (ack_req),
    .eoi_req    (eoi_req),
    .busy       (busy),
    .ack_valid  (ack_valid),
    .ack_id     (ack_id),
    .run_id     (run_id),
    .run_prio   (run_prio),
    .pclr_valid (pclr_valid),
    .pclr_id    (pclr_id),
    .pset_valid (pset_valid),
    .pset_id    (pset_id)
);

// File: tb/test_ack_eoi_tracker.sv
module test_ack_eoi_tracker;
    localparam int N = 8;
    localparam int NONE = 1023;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [9:0]      hp_id = 10'd1023;
    logic [N*8-1:0]  prio_table = '0;
    logic [N-1:0]    trig_edge = '1;
    logic [N-1:0]    model_all = '0;
    logic [N-1:0]    irq_enable = '0;
    logic [N-1:0]    line_level = '0;
    logic [N-1:0]    targets_self = '0;
    logic            ack_req = 1'b0;
    logic            eoi_req = 1'b0;
    logic [9:0]      eoi_id = '0;
    logic            ack_valid;
    logic [9:0]      ack_id;
    logic [9:0]      run_id;
    logic [8:0]      run_prio;
    logic            pclr_valid;
    logic [9:0]      pclr_id;
    logic            pclr_all;
    logic            pset_valid;
    logic [9:0]      pset_id;
    logic            busy;

    int n_checks = 0;
    int n_err    = 0;
    int m_run    = NONE;
    int m_link [N];

    always #4 clk = ~clk;

    ack_eoi_tracker #(.NUM_IRQ(N)) i_ack_eoi_tracker (
        .clk(clk), .rst_n(rst_n), .hp_id(hp_id), .prio_table(prio_table),
        .trig_edge(trig_edge), .model_all(model_all), .irq_enable(irq_enable),
        .line_level(line_level), .targets_self(targets_self),
        .ack_req(ack_req), .eoi_req(eoi_req), .eoi_id(eoi_id),
        .ack_valid(ack_valid), .ack_id(ack_id), .run_id(run_id), .run_prio(run_prio),
        .pclr_valid(pclr_valid), .pclr_id(pclr_id), .pclr_all(pclr_all),
        .pset_valid(pset_valid), .pset_id(pset_id), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int prio_of(input int id);
        if (id >= 0 && id < N) return int'(prio_table[id*8 +: 8]);
        return 256;
    endfunction

    function automatic int rprio_model();
        return (m_run == NONE) ? 256 : prio_of(m_run);
    endfunction

    task automatic check_run(input string req);
        chk({req, " run_id"}, int'(run_id), m_run);
        chk({req, " run_prio (R5)"}, int'(run_prio), rprio_model());
    endtask

    task automatic model_eoi(input int id);
        int tmp;
        if (id >= N || m_run == NONE) return;
        if (id == m_run) begin
            m_run = m_link[id];
        end else begin
            tmp = m_run;
            for (int k = 0; k < N; k++) begin
                if (tmp >= N || m_link[tmp] == NONE) break;
                if (m_link[tmp] == id) begin
                    m_link[tmp] = m_link[id];
                    break;
                end
                tmp = m_link[tmp];
            end
        end
    endtask

    task automatic do_ack(input string req);
        int hp;
        bit ok;
        hp = int'(hp_id);
        @(negedge clk);
        ack_req = 1'b1;
        ok = (hp < N) && (prio_of(hp) < rprio_model());
        @(negedge clk);
        ack_req = 1'b0;
        chk({req, " ack_valid (R12)"}, int'(ack_valid), 1);
        chk({req, " ack_id"}, int'(ack_id), ok ? hp : NONE);
        chk({req, " pclr_valid (R4)"}, int'(pclr_valid), int'(ok));
        if (ok) begin
            chk("R4 pclr_id", int'(pclr_id), hp);
            chk("R4 pclr_all", int'(pclr_all), int'(model_all[hp]));
            m_link[hp] = m_run;
            m_run = hp;
        end
        check_run(req);
    endtask

    task automatic do_eoi(input int id, input string req);
        bit acc;
        bit rl;
        @(negedge clk);
        eoi_id  = 10'(id);
        eoi_req = 1'b1;
        acc = (id < N) && (m_run != NONE);
        rl  = acc && !trig_edge[id % N] && irq_enable[id % N]
              && line_level[id % N] && targets_self[id % N];
        @(negedge clk);
        eoi_req = 1'b0;
        chk({req, " pset_valid (R7)"}, int'(pset_valid), int'(rl));
        if (rl) chk("R7 pset_id", int'(pset_id), id);
        model_eoi(id);
        while (busy) @(negedge clk);
        check_run(req);
    endtask

    task automatic unwind();
        for (int k = 0; k < N + 1; k++) begin
            if (m_run == NONE) break;
            do_eoi(m_run, "R8");
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_link[i] = NONE;
            prio_table[i*8 +: 8] = (i == 0) ? 8'h10 : (i == 7) ? 8'h80 : 8'(8'hE0 - 16 * i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 run_id", int'(run_id), NONE);
        chk("R1 run_prio", int'(run_prio), 256);
        chk("R1 busy", int'(busy), 0);
        chk("R1 ack_valid", int'(ack_valid), 0);
        chk("R1 pclr_valid", int'(pclr_valid), 0);
        chk("R1 pset_valid", int'(pset_valid), 0);

        // R2 spurious offers from idle
        hp_id = 10'd1023; do_ack("R2");
        hp_id = 10'd9;    do_ack("R2");

        // R6 EOI while nothing runs, with a re-armable source
        trig_edge[2] = 1'b0; irq_enable[2] = 1'b1; line_level[2] = 1'b1; targets_self[2] = 1'b1;
        do_eoi(2, "R6");
        trig_edge = '1;

        // R3/R2 exhaustive pairs: nest b over a, gated by strict priority
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                if (a != b) begin
                    hp_id = 10'(a); do_ack("R3");
                    hp_id = 10'(b); do_ack("R2");
                    unwind();
                end
            end
        end

        // R7/R4 sweep over trigger, enable, line, target and model bits
        for (int c = 0; c < 32; c++) begin
            int i;
            i = c % N;
            trig_edge = '1; irq_enable = '0; line_level = '0; targets_self = '0; model_all = '0;
            trig_edge[i]    = c[0];
            irq_enable[i]   = c[1];
            line_level[i]   = c[2];
            targets_self[i] = c[3];
            model_all[i]    = c[4];
            hp_id = 10'(i); do_ack("R4");
            do_eoi(i, "R7");
        end
        trig_edge = '1; irq_enable = '0; line_level = '0; targets_self = '0; model_all = '0;

        // R9 chain 7 -> 5 -> 3 -> 1, complete from the middle
        hp_id = 10'd1; do_ack("R3");
        hp_id = 10'd3; do_ack("R3");
        hp_id = 10'd5; do_ack("R3");
        hp_id = 10'd7; do_ack("R3");
        do_eoi(3, "R9");
        do_eoi(2, "R9");
        // R6 out-of-range completions ignored
        do_eoi(9, "R6");
        do_eoi(1023, "R6");
        unwind();

        // R10 acknowledge during a walk is refused
        hp_id = 10'd1; do_ack("R3");
        hp_id = 10'd3; do_ack("R3");
        hp_id = 10'd5; do_ack("R3");
        hp_id = 10'd7; do_ack("R3");
        @(negedge clk);
        eoi_id = 10'd1; eoi_req = 1'b1;
        @(negedge clk);
        eoi_req = 1'b0;
        chk("R10 busy during walk", int'(busy), 1);
        hp_id = 10'd0; ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        chk("R10 ack during walk", int'(ack_id), NONE);
        chk("R10 run kept", int'(run_id), 7);
        model_eoi(1);
        while (busy) @(negedge clk);
        check_run("R10");

        // R10 EOI during a walk is ignored (chain now 7 -> 5 -> 3)
        @(negedge clk);
        eoi_id = 10'd3; eoi_req = 1'b1;
        @(negedge clk);
        chk("R10 busy before second EOI", int'(busy), 1);
        eoi_id = 10'd7;
        @(negedge clk);
        eoi_req = 1'b0;
        model_eoi(3);
        while (busy) @(negedge clk);
        check_run("R10 EOI ignored");

        // R11 acknowledge and EOI together: EOI wins (chain 7 -> 5)
        hp_id = 10'd0;
        @(negedge clk);
        ack_req = 1'b1; eoi_req = 1'b1; eoi_id = 10'd7;
        @(negedge clk);
        ack_req = 1'b0; eoi_req = 1'b0;
        chk("R11 ack_valid", int'(ack_valid), 1);
        chk("R11 ack_id", int'(ack_id), NONE);
        model_eoi(7);
        check_run("R11");
        unwind();

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule